// File: doc/BRIEF.md
# Vector Boolean Functional Unit

This unit runs one bitwise logical operation over a whole vector. When it is idle and sees a start request, it captures an operation code, a vector length, an element select mask and a scalar value. It then walks the element indices from zero upward and issues one register read per clock. It combines the two operand elements and hands one result element per clock to a vector register write port. Each result is tagged with its element index.

Either operand, or both, can be replaced by the captured 64-bit scalar value. That value is then applied to every element. Besides the four classic Boolean functions, a merge operation picks each result element whole from one operand or the other, as chosen by the mask bit of that element. Start-up cost is paid once per vector. A fixed two-clock gap separates a read from its result, and a one-clock done pulse closes the run.

Top module: `vbool_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_en`, `wr_valid`, `done` and `busy` are all 0.
- R2: The run length N is taken from the low 6 bits of `vlen`, with the value 0 meaning 64, and bits 23..6 are ignored. Exactly N results are produced, in consecutive clocks, with `wr_idx` counting 0, 1, ..., N-1.
- R3: After an accepted start, `rd_en` is high for exactly N consecutive clocks, beginning the clock after the start. During them `rd_idx` steps 0..N-1. The operand elements are expected on `rd_a`/`rd_b` one clock after their read.
- R4: The result for element i is valid exactly 2 clocks after the clock in which `rd_en` was high with `rd_idx` = i.
- R5: Operation code 0 gives a AND b, 1 gives a OR b, 2 gives a XOR b, and 3 gives equivalence, NOT(a XOR b), all bitwise on 64-bit elements.
- R6: Operation code 4 is merge: the result for element i equals operand a when bit i of `mask` is 1, and operand b when it is 0.
- R7: Operation codes 5, 6 and 7 give all-zero results, with the normal count, indices and timing.
- R8: When `scal_on_a` (or `scal_on_b`) is 1 at start, operand a (or b) is `scal_val` for every element, and the corresponding read port data is not used. Both flags may be set together.
- R9: `done` is a single-clock pulse in the clock after the last result. `busy` is high from the clock after an accepted start until the clock before `done`, and low while `done` is high. A start is accepted only when `busy` is 0, and a start raised while `busy` is 1 has no effect.
- R10: Operation code, length, mask, scalar value and scalar flags are captured at the accepted start. Changes to those inputs during a run do not affect its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, accepted when `busy` is 0 |
| opcode | input | 3 | Operation: 0 AND, 1 OR, 2 XOR, 3 equivalence, 4 merge, others zero |
| vlen | input | 24 | Vector length from an address register (low 6 bits used, 0 = 64) |
| mask | input | 64 | Merge select, bit i for element i |
| scal_val | input | 64 | Scalar operand value |
| scal_on_a | input | 1 | Use the scalar value as operand a |
| scal_on_b | input | 1 | Use the scalar value as operand b |
| rd_en | output | 1 | Operand read request for element `rd_idx` |
| rd_idx | output | 6 | Element index to read |
| rd_a | input | 64 | Operand a element, one clock after the read |
| rd_b | input | 64 | Operand b element, one clock after the read |
| wr_valid | output | 1 | Result element valid |
| wr_idx | output | 6 | Element index of the result |
| wr_data | output | 64 | Result element |
| done | output | 1 | One-clock pulse after the last result |
| busy | output | 1 | Run in progress; starts are ignored |

## Verification
The assertions take for granted that `start` is only raised with well-formed inputs beside it. They also assume the read ports return the addressed element exactly one clock after `rd_en`. They do not check data values, only the index stepping, the two-clock read-to-result gap and the done and busy framing. The stimulus keeps within these assumptions by modelling the register file as a one-clock registered read in the bench. It also raises `start` only at an idle or done clock, except for deliberate random pokes while `busy` is 1. Those pokes, and random changes to every captured input during a run, are what R9 and R10 are checked against.

// File: rtl/vbool_pkg.sv
package vbool_pkg;

   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      VB_AND = 3'd0,
      VB_OR  = 3'd1,
      VB_XOR = 3'd2,
      VB_EQV = 3'd3,
      VB_MRG = 3'd4
   } vb_opc_e;

endpackage

// File: rtl/vbool_seq.sv
// Element sequencer: issues one operand read per clock and aligns the
// index and last-element flag with the returned read data.
module vbool_seq #(
   parameter int MAX_LEN = 64,
   parameter int LEN_W   = 24,
   localparam int IDX_W  = $clog2(MAX_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [LEN_W-1:0] vlen,
   output logic             rd_en,
   output logic [IDX_W-1:0] rd_idx,
   output logic             s1_valid,
   output logic [IDX_W-1:0] s1_idx,
   output logic             s1_last,
   output logic             seq_busy
);

   logic             issuing;
   logic [IDX_W-1:0] cnt;
   logic [IDX_W-1:0] last_idx;
   logic             at_last;

   assign at_last  = (cnt == last_idx);
   assign rd_en    = issuing;
   assign rd_idx   = cnt;
   assign seq_busy = issuing | s1_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issuing  <= 1'b0;
         cnt      <= '0;
         last_idx <= '0;
      end else if (accept) begin
         issuing  <= 1'b1;
         cnt      <= '0;
         // a zero length field wraps to MAX_LEN-1, i.e. a full vector
         last_idx <= vlen[IDX_W-1:0] - 1'b1;
      end else if (issuing) begin
         cnt <= cnt + 1'b1;
         if (at_last) issuing <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_idx   <= '0;
         s1_last  <= 1'b0;
      end else begin
         s1_valid <= issuing;
         s1_idx   <= cnt;
         s1_last  <= issuing & at_last;
      end
   end

endmodule

// File: rtl/vbool_opsel.sv
// Operand selection: read port data or the broadcast scalar.
module vbool_opsel #(
   parameter int ELEM_W    = 64,
   parameter bit SCALAR_EN = 1'b1
) (
   input  logic [ELEM_W-1:0] rd_a,
   input  logic [ELEM_W-1:0] rd_b,
   input  logic [ELEM_W-1:0] scal,
   input  logic              use_a,
   input  logic              use_b,
   output logic [ELEM_W-1:0] op_a,
   output logic [ELEM_W-1:0] op_b
);

   generate
      if (SCALAR_EN) begin : g_bcast
         assign op_a = use_a ? scal : rd_a;
         assign op_b = use_b ? scal : rd_b;
      end else begin : g_plain
         logic unused_sel;
         assign unused_sel = use_a ^ use_b ^ (^scal);
         assign op_a = rd_a;
         assign op_b = rd_b;
      end
   endgenerate

endmodule

// File: rtl/vbool_alu.sv
// Result stage: the logic function, the result register and the done flag.
module vbool_alu
   import vbool_pkg::*;
#(
   parameter int ELEM_W = 64,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IDX_W-1:0]  in_idx,
   input  logic              in_last,
   input  logic [OPC_W-1:0]  opc,
   input  logic              msel,
   input  logic [ELEM_W-1:0] op_a,
   input  logic [ELEM_W-1:0] op_b,
   output logic              wr_valid,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [ELEM_W-1:0] wr_data,
   output logic              done
);

   logic [ELEM_W-1:0] res;
   logic              wr_last;

   always_comb begin
      unique case (opc)
         VB_AND:  res = op_a & op_b;
         VB_OR:   res = op_a | op_b;
         VB_XOR:  res = op_a ^ op_b;
         VB_EQV:  res = ~(op_a ^ op_b);
         VB_MRG:  res = msel ? op_a : op_b;
         default: res = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
         wr_last  <= 1'b0;
         done     <= 1'b0;
      end else begin
         wr_valid <= in_valid;
         wr_idx   <= in_idx;
         wr_last  <= in_last;
         done     <= wr_last;
         if (in_valid) wr_data <= res;
      end
   end

endmodule

// File: rtl/vbool_unit.sv
module vbool_unit
   import vbool_pkg::*;
#(
   parameter int ELEM_W    = 64,
   parameter int MAX_LEN   = 64,
   parameter int LEN_W     = 24,
   parameter bit SCALAR_EN = 1'b1,
   localparam int IDX_W    = $clog2(MAX_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [LEN_W-1:0]  vlen,
   input  logic [MAX_LEN-1:0] mask,
   input  logic [ELEM_W-1:0] scal_val,
   input  logic              scal_on_a,
   input  logic              scal_on_b,
   output logic              rd_en,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [ELEM_W-1:0] rd_a,
   input  logic [ELEM_W-1:0] rd_b,
   output logic              wr_valid,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [ELEM_W-1:0] wr_data,
   output logic              done,
   output logic              busy
);

   generate
      if ((MAX_LEN < 2) || ((MAX_LEN & (MAX_LEN - 1)) != 0)) begin : g_bad_len
         $error("vbool_unit: MAX_LEN must be a power of two, at least 2");
      end
      if (LEN_W < IDX_W) begin : g_bad_lenw
         $error("vbool_unit: LEN_W narrower than the element index");
      end
      if (ELEM_W < 1) begin : g_bad_elem
         $error("vbool_unit: ELEM_W must be positive");
      end
   endgenerate

   logic               accept;
   logic               seq_busy;
   logic               s1_valid;
   logic               s1_last;
   logic [IDX_W-1:0]   s1_idx;
   logic [OPC_W-1:0]   opc_r;
   logic [MAX_LEN-1:0] mask_r;
   logic [ELEM_W-1:0]  scal_r;
   logic               sa_r;
   logic               sb_r;
   logic [ELEM_W-1:0]  op_a;
   logic [ELEM_W-1:0]  op_b;

   assign busy   = seq_busy | wr_valid;
   assign accept = start & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opc_r  <= '0;
         mask_r <= '0;
         scal_r <= '0;
         sa_r   <= 1'b0;
         sb_r   <= 1'b0;
      end else if (accept) begin
         opc_r  <= opcode;
         mask_r <= mask;
         scal_r <= scal_val;
         sa_r   <= scal_on_a;
         sb_r   <= scal_on_b;
      end
   end

   vbool_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .vlen     (vlen),
      .rd_en    (rd_en),
      .rd_idx   (rd_idx),
      .s1_valid (s1_valid),
      .s1_idx   (s1_idx),
      .s1_last  (s1_last),
      .seq_busy (seq_busy)
   );

   vbool_opsel #(.ELEM_W(ELEM_W), .SCALAR_EN(SCALAR_EN)) u_opsel (
      .rd_a  (rd_a),
      .rd_b  (rd_b),
      .scal  (scal_r),
      .use_a (sa_r),
      .use_b (sb_r),
      .op_a  (op_a),
      .op_b  (op_b)
   );

   vbool_alu #(.ELEM_W(ELEM_W), .IDX_W(IDX_W)) u_alu (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (s1_valid),
      .in_idx   (s1_idx),
      .in_last  (s1_last),
      .opc      (opc_r),
      .msel     (mask_r[s1_idx]),
      .op_a     (op_a),
      .op_b     (op_b),
      .wr_valid (wr_valid),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .done     (done)
   );

endmodule

// File: rtl/vbool_chk.sv
module vbool_chk #(
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_en,
   input logic [IDX_W-1:0] rd_idx,
   input logic             wr_valid,
   input logic [IDX_W-1:0] wr_idx,
   input logic             done,
   input logic             busy
);

   p_first_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_en) |-> rd_idx == '0);

   p_read_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en)) |-> rd_idx == IDX_W'($past(rd_idx) + 1'b1));

   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> ##2 wr_valid);

   p_wr_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid) |-> wr_idx == '0);

   p_wr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && $past(wr_valid)) |-> wr_idx == IDX_W'($past(wr_idx) + 1'b1));

   p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!wr_valid && $past(wr_valid)));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_idle_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

bind vbool_unit vbool_chk #(.IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .rd_idx   (rd_idx),
   .wr_valid (wr_valid),
   .wr_idx   (wr_idx),
   .done     (done),
   .busy     (busy)
);

// File: tb/vbool_unit_bench.sv
module vbool_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [2:0]  opcode;
   logic [23:0] vlen;
   logic [63:0] mask;
   logic [63:0] scal_val;
   logic        scal_on_a;
   logic        scal_on_b;
   logic        rd_en;
   logic [5:0]  rd_idx;
   logic [63:0] rd_a;
   logic [63:0] rd_b;
   logic        wr_valid;
   logic [5:0]  wr_idx;
   logic [63:0] wr_data;
   logic        done;
   logic        busy;

   logic [63:0] va [64];
   logic [63:0] vb [64];

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   vbool_unit u_vbool_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .vlen(vlen),
      .mask(mask), .scal_val(scal_val), .scal_on_a(scal_on_a),
      .scal_on_b(scal_on_b), .rd_en(rd_en), .rd_idx(rd_idx), .rd_a(rd_a),
      .rd_b(rd_b), .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
      .done(done), .busy(busy)
   );

   // register file model: one-clock registered read
   always @(posedge clk) begin
      if (rd_en) begin
         rd_a <= va[rd_idx];
         rd_b <= vb[rd_idx];
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] expect_res(input logic [2:0] op,
      input logic [63:0] a, input logic [63:0] b, input logic m);
      case (op)
         3'd0: return a & b;
         3'd1: return a | b;
         3'd2: return a ^ b;
         3'd3: return ~(a ^ b);
         3'd4: return m ? a : b;
         default: return 64'd0;
      endcase
   endfunction

   task automatic fill_regs();
      for (int i = 0; i < 64; i++) begin
         va[i] = {$urandom, $urandom};
         vb[i] = {$urandom, $urandom};
      end
   endtask

   // called at a negedge where busy is 0; returns at the done negedge
   task automatic run(input logic [2:0] op, input logic [23:0] vl,
                      input bit sa, input bit sb, input logic [63:0] sv,
                      input logic [63:0] mk, input string tag);
      int n;
      logic [63:0] ea;
      logic [63:0] eb;
      int wi;
      n = (vl[5:0] == 6'd0) ? 64 : int'(vl[5:0]);
      start = 1'b1; opcode = op; vlen = vl; mask = mk;
      scal_val = sv; scal_on_a = sa; scal_on_b = sb;
      for (int t = 1; t <= n + 3; t++) begin
         @(negedge clk);
         chk(rd_en == (t <= n), "R3 rd_en", 64'(rd_en), 64'(t <= n));
         if (t <= n)
            chk(rd_idx == 6'(t - 1), "R3 rd_idx", 64'(rd_idx), 64'(t - 1));
         chk(wr_valid == (t >= 3 && t <= n + 2), "R4 wr_valid",
             64'(wr_valid), 64'(t >= 3 && t <= n + 2));
         if (t >= 3 && t <= n + 2) begin
            wi = t - 3;
            ea = sa ? sv : va[wi];
            eb = sb ? sv : vb[wi];
            chk(wr_idx == 6'(wi), "R2 wr_idx", 64'(wr_idx), 64'(wi));
            chk(wr_data == expect_res(op, ea, eb, mk[wi]), tag, wr_data,
                expect_res(op, ea, eb, mk[wi]));
         end
         chk(done == (t == n + 3), "R9 done", 64'(done), 64'(t == n + 3));
         chk(busy == (t <= n + 2), "R9 busy", 64'(busy), 64'(t <= n + 2));
         if (t < n + 3) begin
            // R9 and R10: junk on every captured input while running
            start     = busy ? 1'($urandom_range(0, 1)) : 1'b0;
            opcode    = 3'($urandom);
            vlen      = 24'($urandom);
            mask      = {$urandom, $urandom};
            scal_val  = {$urandom, $urandom};
            scal_on_a = 1'($urandom);
            scal_on_b = 1'($urandom);
         end
      end
      start = 1'b0;
   endtask

   initial begin
      #1_000_000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; start = 1'b0; opcode = '0; vlen = '0; mask = '0;
      scal_val = '0; scal_on_a = 1'b0; scal_on_b = 1'b0;
      fill_regs();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({rd_en, wr_valid, done, busy} == 4'b0, "R1 reset outputs",
          64'({rd_en, wr_valid, done, busy}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({rd_en, wr_valid, done, busy} == 4'b0, "R1 after reset",
          64'({rd_en, wr_valid, done, busy}), 64'd0);

      run(3'd0, 24'd8, 0, 0, '0, '0, "R5 and");
      run(3'd1, 24'd8, 0, 0, '0, '0, "R5 or");
      run(3'd2, 24'd8, 0, 0, '0, '0, "R5 xor");
      run(3'd3, 24'd8, 0, 0, '0, '0, "R5 eqv");
      run(3'd4, 24'd16, 0, 0, '0, 64'hAAAA_5555_F0F0_0F0F, "R6 merge");
      run(3'd4, 24'd0, 0, 0, '0, 64'h8000_0000_0000_0001, "R6 merge full");
      run(3'd5, 24'd5, 0, 0, '0, '1, "R7 code5");
      run(3'd6, 24'd5, 0, 0, '0, '1, "R7 code6");
      run(3'd7, 24'd5, 0, 0, '0, '1, "R7 code7");
      run(3'd2, 24'd0, 0, 0, '0, '0, "R2 len0 is 64");
      run(3'd1, 24'd64, 0, 0, '0, '0, "R2 len64");
      run(3'd0, 24'hFFFFC3, 0, 0, '0, '0, "R2 high bits ignored");
      run(3'd3, 24'd1, 0, 0, '0, '0, "R2 len1");
      run(3'd2, 24'd9, 1, 0, 64'h0123_4567_89AB_CDEF, '0, "R8 scalar a");
      run(3'd4, 24'd9, 0, 1, 64'hFEDC_BA98_7654_3210, 64'h155, "R8 scalar b");
      run(3'd1, 24'd4, 1, 1, 64'h00FF_00FF_1234_5678, '0, "R8 scalar both");
      fill_regs();
      run(3'd0, 24'd20, 0, 0, '0, '0, "R10 captured inputs");
      for (int k = 0; k < 40; k++) begin
         fill_regs();
         run(3'($urandom), 24'($urandom), 1'($urandom_range(0, 3) == 0),
             1'($urandom_range(0, 3) == 0), {$urandom, $urandom},
             {$urandom, $urandom}, "R5 R6 R7 R8 random");
      end
      repeat (2) @(negedge clk);
      chk({rd_en, wr_valid, busy} == 3'b0, "R9 idle after run",
          64'({rd_en, wr_valid, busy}), 64'd0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule